// File: doc/BRIEF.md
# ECC Error Status Logger

This block is the error logging word of a memory controller. An ECC checker, outside the block, reports each failing access as a correctable or an uncorrectable event together with the chip-select row (one of eight) that the access hit. The logger keeps one sticky flag and one captured row number per error class. The row is the one from the first error after the flag was last clear.

The same 32-bit word holds the control fields. These are the ECC operating mode, a diagnostic enable, and one system-error enable per error class. Software reads the word through a simple configuration port and writes it there too. A write stores the control fields. A one written to a flag position clears that flag. The block drives a system-error line while an enabled class has its flag set.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, the read word is 0 and `serr_o` is low. Mode 0 means disabled.
- R2: Read bits 31:16, 13, 7 and 3 are always 0. Row numbers 0..7 appear zero-extended in the 4-bit row fields.
- R3: An uncorrectable event (`ev_ue`) sets bit 8 and captures `ev_row` into bits 7:4. A correctable event (`ev_ce`) sets bit 9 and captures `ev_row` into bits 3:0. Both are visible on the read word in the cycle after the event edge.
- R4: A row field is captured only when its flag was clear. While the flag stays set, later events of that class leave the row unchanged.
- R5: A write with bit 8 (or bit 9) at 1 clears that flag. A write with the bit at 0 leaves the flag as it was.
- R6: An event in the same cycle as a clearing write of its flag keeps the flag set, and the row keeps its old value.
- R7: A write stores bits 11:10 (mode: 0 off, 1 check only, 2 correct single/detect double, 3 correct plus scrub), bit 12 (diagnostic), bit 14 (system-error enable for uncorrectable) and bit 15 (system-error enable for correctable). Each is read back unchanged.
- R8: While the stored mode is 0, events set no flag and capture no row.
- R9: `serr_o` is high exactly while (bit 8 and bit 14) or (bit 9 and bit 15) hold in the stored word.
- R10: Clearing a flag leaves its row field at the last captured value until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_ue | input | 1 | Uncorrectable error event this cycle |
| ev_ce | input | 1 | Correctable error event this cycle |
| ev_row | input | 3 | Chip-select row of the failing access |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current register word |
| serr_o | output | 1 | System-error signal |

## Verification
Assertions check on every cycle that the flags are sticky, that each rise of a flag comes from an event, that a row field stays stable while its flag is set, and that disabled mode and same-cycle collisions behave as required. Only the bench scenarios can show several things: the exact packing of fields into the word, the clearing of each flag by its own bit, the value retained after a clear, and the system-error line against every enable combination. The bench runs a long random mix against a reference model to cover these.

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_ue,
  input  logic             ev_ce,
  input  logic [ROW_W-1:0] ev_row,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             serr_o
);
  localparam int FIELD_W = 4;
  localparam int PAD_W   = FIELD_W - ROW_W;

  logic [1:0]       mode_q;
  logic             diag_q, en_ue_q, en_ce_q;
  logic             ue_q, ce_q;
  logic [ROW_W-1:0] ue_row_q, ce_row_q;

  wire active = (mode_q != 2'd0);
  wire ue_hit = active && ev_ue;
  wire ce_hit = active && ev_ce;
  wire ue_clr = cfg_wr && cfg_wdata[8];
  wire ce_clr = cfg_wr && cfg_wdata[9];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      diag_q   <= 1'b0;
      en_ue_q  <= 1'b0;
      en_ce_q  <= 1'b0;
      ue_q     <= 1'b0;
      ce_q     <= 1'b0;
      ue_row_q <= '0;
      ce_row_q <= '0;
    end else begin
      if (cfg_wr) begin
        mode_q  <= cfg_wdata[11:10];
        diag_q  <= cfg_wdata[12];
        en_ue_q <= cfg_wdata[14];
        en_ce_q <= cfg_wdata[15];
      end
      ue_q <= ue_hit | (ue_q & ~ue_clr);
      ce_q <= ce_hit | (ce_q & ~ce_clr);
      if (ue_hit && !ue_q) ue_row_q <= ev_row;
      if (ce_hit && !ce_q) ce_row_q <= ev_row;
    end
  end

  assign cfg_rdata = {16'h0, en_ce_q, en_ue_q, 1'b0, diag_q, mode_q, ce_q, ue_q,
                      {PAD_W{1'b0}}, ue_row_q, {PAD_W{1'b0}}, ce_row_q};
  assign serr_o = (ue_q & en_ue_q) | (ce_q & en_ce_q);

  // R5: a flag only drops through a clearing write
  a_r5_ue_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ue_q && !ue_clr |=> ue_q);
  a_r5_ce_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q && !ce_clr |=> ce_q);
  // R3: every rise of a flag is caused by an event of its class
  a_r3_ue_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ue_q) |-> $past(ev_ue));
  a_r3_ce_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_q) |-> $past(ev_ce));
  // R4: row held while its flag is set
  a_r4_ue_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ue_q |=> $stable(cfg_rdata[7:4]));
  a_r4_ce_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q |=> $stable(cfg_rdata[3:0]));
  // R6: event beats a same-cycle clear
  a_r6_ue_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ue && active |=> cfg_rdata[8]);
  a_r6_ce_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ce && active |=> cfg_rdata[9]);
  // R8: disabled mode never raises a flag
  a_r8_off_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !ue_q && !ce_q |=> !cfg_rdata[8] && !cfg_rdata[9]);
endmodule

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_ue = 1'b0, ev_ce = 1'b0;
  logic [2:0]  ev_row = '0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        serr_o;

  int n_chk = 0, n_fail = 0;

  logic [1:0] m_mode; logic m_diag, m_eu, m_ec, m_ue, m_ce;
  logic [2:0] m_urow, m_crow;

  always #5 clk = ~clk;

  ecc_err_log u_dut (.clk(clk), .rst_n(rst_n), .ev_ue(ev_ue), .ev_ce(ev_ce),
    .ev_row(ev_row), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .serr_o(serr_o));

  function automatic logic [31:0] exp_word();
    return {16'h0, m_ec, m_eu, 1'b0, m_diag, m_mode, m_ce, m_ue,
            1'b0, m_urow, 1'b0, m_crow};
  endfunction

  function automatic logic exp_serr();
    return (m_ue & m_eu) | (m_ce & m_ec);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_diag = 0; m_eu = 0; m_ec = 0; m_ue = 0; m_ce = 0;
    m_urow = 0; m_crow = 0;
  endtask

  // one cycle: drive at negedge, update model, check at next negedge
  task automatic step(input logic wr, input logic [31:0] wd,
                      input logic ue, input logic ce, input logic [2:0] row,
                      input string req);
    logic on;
    cfg_wr = wr; cfg_wdata = wd; ev_ue = ue; ev_ce = ce; ev_row = row;
    on = (m_mode != 0);
    if (on && ue && !m_ue) m_urow = row;
    if (on && ce && !m_ce) m_crow = row;
    m_ue = (on && ue) || (m_ue && !(wr && wd[8]));
    m_ce = (on && ce) || (m_ce && !(wr && wd[9]));
    if (wr) begin
      m_mode = wd[11:10]; m_diag = wd[12]; m_eu = wd[14]; m_ec = wd[15];
    end
    @(posedge clk); @(negedge clk);
    cfg_wr = 0; ev_ue = 0; ev_ce = 0;
    chk(req, cfg_rdata, exp_word());
    chk({req, " serr R9"}, {31'h0, serr_o}, {31'h0, exp_serr()});
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset word", cfg_rdata, 32'h0);
    chk("R1 reset serr", {31'h0, serr_o}, 32'h0);

    step(0, 0, 1, 1, 3'd5, "R8 mode off ignores");
    step(1, 32'hFFFF_E3FF, 0, 0, 0, "R7 control write, R2 reserved");
    chk("R2 reserved zero", cfg_rdata & 32'hFFFF_2088, 32'h0);
    step(1, 32'h0000_0400, 0, 0, 0, "R7 mode 1");
    step(0, 0, 1, 0, 3'd6, "R3 ue capture");
    step(0, 0, 0, 1, 3'd7, "R3 ce capture, R2 row 7");
    step(0, 0, 1, 1, 3'd2, "R4 row held");
    step(1, 32'h0000_0400, 0, 0, 0, "R5 write 0 keeps flags");
    step(1, 32'h0000_0500, 1, 0, 3'd1, "R6 event beats clear");
    step(1, 32'h0000_0700, 0, 0, 0, "R5 clear both, R10 rows kept");
    step(0, 0, 1, 0, 3'd3, "R10 recapture after clear");
    step(1, 32'h0000_4800, 0, 0, 0, "R9 ue enable");
    step(1, 32'h0000_8900, 0, 1, 3'd4, "R9 ce enable");
    step(1, 32'h0000_0200, 0, 0, 0, "R1 mode off via write");
    step(0, 0, 1, 1, 3'd0, "R8 off after write");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] wd;
      logic wr;
      wr = ($urandom_range(0, 7) == 0);
      wd = $urandom;
      step(wr, wd, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           3'($urandom_range(0, 7)), "random R3/R4/R5/R6/R7/R8/R10");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule